// File: doc/BRIEF.md
# Add/Subtract/Compare Flag Unit

This block is the arithmetic core of a small 8-bit processor datapath. Each cycle it takes an accumulator operand, a second operand, a carry input and a 2-bit operation code. It registers the result of an add-with-carry, a subtract-with-carry or a compare, together with five condition flags: negative, overflow, half-carry, zero and carry. Beside the flags it drives an update mask, so the surrounding status register knows which flags the operation is allowed to change.

Subtraction uses no separate subtractor. The second operand is inverted and added with the carry input. A carry-out of 1 therefore means that no borrow occurred. Compare uses the same adder with a forced carry of 1. It produces no result value, and it declares overflow and half-carry as untouched.

All outputs are registered, so results appear one clock after the inputs are sampled. An active-low asynchronous reset clears every output.

Top module: `flag_alu`

## Requirements
- R1: With op code 0 (add), one cycle after the inputs are sampled, {flags[0], res} equals opa + opb + cin as a 9-bit sum.
- R2: With op code 1 (subtract), {flags[0], res} equals opa + ~opb + cin, so flags[0]=1 means no borrow.
- R3: For op codes 0 and 1, flags[2] (half-carry) is the carry out of bit 3 of the low-nibble sum of opa, the effective second operand and cin.
- R4: For op codes 0 and 1, flags[3] (overflow) is set when opa and the effective second operand share a sign and the result's sign differs from it.
- R5: For op codes 0 and 1, flags[4] (negative) equals res bit 7, and flags[1] (zero) is set when res is 0.
- R6: With op code 2 (compare), flags[0] = (opa >= opb) unsigned, flags[4] and flags[1] come from the 8-bit difference opa - opb, cin has no effect, and res, flags[3] and flags[2] are 0.
- R7: upd_mask uses the same bit order as flags ({N,V,H,Z,C} at bits 4..0). It is 5'b11111 for op codes 0 and 1, 5'b10011 for op code 2, and 5'b00000 for op code 3.
- R8: With op code 3 (idle), res and flags are 0 whatever the operands and carry.
- R9: While rst_n is low, res, flags and upd_mask are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op | input | 2 | Operation: 0 add, 1 subtract, 2 compare, 3 idle |
| opa | input | WIDTH | Accumulator operand |
| opb | input | WIDTH | Second operand |
| cin | input | 1 | Carry input |
| res | output | WIDTH | Registered result |
| flags | output | 5 | Registered {N,V,H,Z,C} |
| upd_mask | output | 5 | Flags changed by the last operation, same order |

## Verification
The bench builds the unit with its default parameters: WIDTH of 8 and the half-carry taken at nibble boundary 4. At these values every sign, nibble and carry boundary can be reached with hand-picked 8-bit operands. A vector table covers carry and half-carry chains, both directions of signed overflow, zero results and equal, smaller and larger compares. A strided sweep over operand pairs and both carry values then checks the sum, carry and overflow of add and subtract against arithmetic computed in the bench.

// File: rtl/flag_alu.sv
module flag_alu #(
  parameter int WIDTH = 8,
  parameter int NIB   = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       op,
  input  logic [WIDTH-1:0] opa,
  input  logic [WIDTH-1:0] opb,
  input  logic             cin,
  output logic [WIDTH-1:0] res,
  output logic [4:0]       flags,
  output logic [4:0]       upd_mask
);
  localparam logic [1:0] OP_ADD  = 2'd0;
  localparam logic [1:0] OP_SUB  = 2'd1;
  localparam logic [1:0] OP_CMP  = 2'd2;
  localparam logic [1:0] OP_IDLE = 2'd3;
  localparam int MSB = WIDTH - 1;

  logic             arith, active, c_eff, ovf;
  logic [WIDTH-1:0] b_eff;
  logic [WIDTH:0]   sum;
  logic [NIB:0]     nsum;

  assign arith  = (op == OP_ADD) || (op == OP_SUB);
  assign active = (op != OP_IDLE);
  assign b_eff  = (op == OP_ADD) ? opb : ~opb;
  assign c_eff  = (op == OP_CMP) ? 1'b1 : cin;
  assign sum    = {1'b0, opa} + {1'b0, b_eff} + {{WIDTH{1'b0}}, c_eff};
  assign nsum   = {1'b0, opa[NIB-1:0]} + {1'b0, b_eff[NIB-1:0]} + {{NIB{1'b0}}, c_eff};
  assign ovf    = (opa[MSB] == b_eff[MSB]) && (sum[MSB] != opa[MSB]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res      <= '0;
      flags    <= '0;
      upd_mask <= '0;
    end else begin
      res      <= arith ? sum[MSB:0] : '0;
      flags    <= {active & sum[MSB],
                   arith & ovf,
                   arith & nsum[NIB],
                   active & (sum[MSB:0] == '0),
                   active & sum[WIDTH]};
      upd_mask <= arith ? 5'b11111 : (op == OP_CMP) ? 5'b10011 : 5'b00000;
    end
  end

  // R1
  p_add_sum_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(op) == OP_ADD) |->
      {flags[0], res} == ({1'b0, $past(opa)} + {1'b0, $past(opb)} + {{WIDTH{1'b0}}, $past(cin)}));

  // R2
  p_sub_sum_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(op) == OP_SUB) |->
      {flags[0], res} == ({1'b0, $past(opa)} + {1'b0, ~$past(opb)} + {{WIDTH{1'b0}}, $past(cin)}));

  // R4
  p_add_ovf_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(op) == OP_ADD && $past(opa[MSB]) == $past(opb[MSB])) |->
      flags[3] == (res[MSB] != $past(opa[MSB])));

  // R5
  p_nz_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && ($past(op) == OP_ADD || $past(op) == OP_SUB)) |->
      (flags[4] == res[MSB]) && (flags[1] == (res == '0)));

  // R6
  p_cmp_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(op) == OP_CMP) |->
      (flags[0] == ($past(opa) >= $past(opb))) && (res == '0) && !flags[3] && !flags[2]);

  // R7
  p_mask_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(op) == OP_CMP) |-> upd_mask == 5'b10011);

  // R8
  p_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(op) == OP_IDLE) |->
      (res == '0) && (flags == 5'b00000) && (upd_mask == 5'b00000));
endmodule

// File: tb/flag_alu_test.sv
`timescale 1ns/1ps
module flag_alu_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] op = 2'd3;
  logic [7:0] opa = 8'h00, opb = 8'h00;
  logic       cin = 1'b0;
  logic [7:0] res;
  logic [4:0] flags, upd_mask;
  int total = 0, bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  flag_alu uut (.clk(clk), .rst_n(rst_n), .op(op), .opa(opa), .opb(opb), .cin(cin),
                .res(res), .flags(flags), .upd_mask(upd_mask));

  // {op, a, b, cin, res, flags{N,V,H,Z,C}, mask}
  localparam logic [36:0] VEC [13] = '{
    {2'd0, 8'h12, 8'h34, 1'b0, 8'h46, 5'b00000, 5'b11111},
    {2'd0, 8'h0F, 8'h01, 1'b0, 8'h10, 5'b00100, 5'b11111},
    {2'd0, 8'h7F, 8'h01, 1'b0, 8'h80, 5'b11100, 5'b11111},
    {2'd0, 8'hFF, 8'h01, 1'b0, 8'h00, 5'b00111, 5'b11111},
    {2'd0, 8'h80, 8'h80, 1'b1, 8'h01, 5'b01001, 5'b11111},
    {2'd1, 8'h50, 8'h10, 1'b1, 8'h40, 5'b00101, 5'b11111},
    {2'd1, 8'h10, 8'h20, 1'b1, 8'hF0, 5'b10100, 5'b11111},
    {2'd1, 8'h80, 8'h01, 1'b1, 8'h7F, 5'b01001, 5'b11111},
    {2'd1, 8'h05, 8'h05, 1'b0, 8'hFF, 5'b10000, 5'b11111},
    {2'd2, 8'h30, 8'h30, 1'b0, 8'h00, 5'b00011, 5'b10011},
    {2'd2, 8'h20, 8'h21, 1'b1, 8'h00, 5'b10000, 5'b10011},
    {2'd2, 8'hFF, 8'h00, 1'b0, 8'h00, 5'b10001, 5'b10011},
    {2'd3, 8'hAA, 8'h55, 1'b1, 8'h00, 5'b00000, 5'b00000}
  };

  task automatic check(input string tag, input logic [17:0] act, input logic [17:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic apply(input logic [1:0] o, input logic [7:0] a, input logic [7:0] b, input logic c);
    @(negedge clk);
    op = o; opa = a; opb = b; cin = c;
    @(negedge clk);
  endtask

  initial begin
    #50000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    // R9: outputs cleared in reset even with live inputs
    op = 2'd0; opa = 8'hFF; opb = 8'hFF; cin = 1'b1;
    repeat (3) @(negedge clk);
    check("R9 reset", {res, flags, upd_mask}, 18'h0);
    rst_n = 1'b1;

    foreach (VEC[i]) begin
      apply(VEC[i][36:35], VEC[i][34:27], VEC[i][26:19], VEC[i][18]);
      check($sformatf("R1-R8 vec%0d R5 R7", i), {res, flags, upd_mask}, VEC[i][17:0]);
    end

    // R6: cin has no effect on compare
    apply(2'd2, 8'h21, 8'h20, 1'b0);
    check("R6 cmp cin0", {res, flags, upd_mask}, {8'h00, 5'b00001, 5'b10011});
    apply(2'd2, 8'h21, 8'h20, 1'b1);
    check("R6 cmp cin1", {res, flags, upd_mask}, {8'h00, 5'b00001, 5'b10011});

    // R3: half-carry from carry-in alone
    apply(2'd0, 8'h0F, 8'h00, 1'b1);
    check("R3 half via cin", {res, flags, upd_mask}, {8'h10, 5'b00100, 5'b11111});

    // R8: idle with carry-producing operands
    apply(2'd3, 8'hFF, 8'hFF, 1'b1);
    check("R8 idle", {res, flags, upd_mask}, 18'h0);

    // R1 R2 R4 sweep
    for (int a = 0; a < 256; a += 37)
      for (int b = 0; b < 256; b += 29)
        for (int c = 0; c < 2; c++)
          for (int o = 0; o < 2; o++) begin
            logic [7:0] eb;
            logic [8:0] s;
            logic v;
            eb = (o == 0) ? 8'(b) : ~8'(b);
            s = 9'(a) + 9'(eb) + 9'(c);
            v = (a[7] == eb[7]) && (s[7] != a[7]);
            apply(2'(o), 8'(a), 8'(b), c[0]);
            check(o == 0 ? "R1 R4 add sweep" : "R2 R4 sub sweep",
                  {8'h00, res, flags[3], flags[0]}, {8'h00, s[7:0], v, s[8]});
          end

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule